// File: doc/BRIEF.md
# Programmable TFT Raster Timing Generator

This block produces the timing skeleton of a TFT panel scan. From three packed 32-bit timing words it derives the active width, the active line count, the horizontal and vertical porches and the sync widths. It then runs a pixel position counter that advances once per pixel tick. The tick comes from dividing the core clock by a programmable divisor. The outputs are horizontal and vertical sync, a data-enable level, the current pixel and line position, a divided pixel clock, a pulse on the last pixel of every frame, and a completion pulse once scanning has stopped.

Software sets the timing words while the raster is off and then raises the enable. Each line runs in the order active pixels, front porch, sync pulse, back porch. Each frame follows the same order in lines. Vertical sync does not switch at a line boundary: it switches together with the falling (trailing) edge of horizontal sync. When the enable is lowered, the frame in progress is scanned to its end. The block then goes idle and reports completion with a one-cycle pulse.

Top module: `lcd_raster_timer`

## Requirements
- R1: `pixelTick` is high for one core cycle every D cycles while the raster runs, where D is `clkDivisor` and any divisor value of 0 or 1 counts as 2. The first tick comes D cycles after the run starts, and no tick occurs while idle.
- R2: Horizontal front porch, back porch and sync width each last (field+1) pixels. Each field is 10 bits. The front porch takes bits [7:0] from word0[23:16] and bits [9:8] from word2[1:0]. The back porch takes bits [7:0] from word0[31:24] and bits [9:8] from word2[5:4]. The sync width takes bits [5:0] from word0[15:10] and bits [9:6] from word2[30:27].
- R3: Active width is (F+1)*16 pixels, where the 7-bit field F has bit 6 at word0[3] and bits [5:0] at word0[9:4].
- R4: Active line count is (L+1), where the 11-bit field L has bits [9:0] at word1[9:0] and bit 10 at word2[26].
- R5: Vertical back porch (word1[31:24]) and front porch (word1[23:16]) are line counts used directly, and may be zero. Vertical sync lasts word1[15:10]+1 lines. Lines run in the order active, front porch, sync, back porch.
- R6: While running, `pixelCount` and `lineCount` give the position, starting at 0,0 and advancing on each tick. `dataEnable` is high exactly when pixelCount < width and lineCount < lines.
- R7: Horizontal sync is active for pixelCount in [width+hfp, width+hfp+hsw). `hsyncOut` equals the active level XOR `hsyncInvert`.
- R8: Vertical sync becomes active at the tick where horizontal sync ends on line (lines+vfp-1). It becomes inactive at the same point of line (lines+vfp+vsw-1). `vsyncOut` equals the active level XOR `vsyncInvert`.
- R9: `pixelClkOut` is 0 in the cycle after a tick and 1 in a tick cycle; more generally it is high when the divider phase is at least D/2. The result is XORed with `pclkInvert`, so while idle it equals `pclkInvert`.
- R10: `frameEnd` is high exactly in the tick cycle at the last position of the frame.
- R11: After `rasterEnable` falls, scanning continues to the end of the current frame. `frameDone` then pulses for one cycle, in the cycle after the final tick. From that cycle on the block is idle: position 0,0, `dataEnable` low, both syncs inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasterEnable | input | 1 | Start scanning when high; a fall requests a stop at frame end |
| timingWord0 | input | 32 | Horizontal timing word |
| timingWord1 | input | 32 | Vertical timing word |
| timingWord2 | input | 32 | Extension bits for the horizontal fields and the line count |
| clkDivisor | input | DIV_W | Core clocks per pixel (0 and 1 act as 2) |
| hsyncInvert | input | 1 | Invert horizontal sync polarity |
| vsyncInvert | input | 1 | Invert vertical sync polarity |
| pclkInvert | input | 1 | Invert the pixel clock output |
| pixelTick | output | 1 | One-cycle pixel clock enable |
| pixelClkOut | output | 1 | Divided pixel clock level |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| dataEnable | output | 1 | Active-video indication |
| pixelCount | output | HCNT_W | Current pixel position in the line |
| lineCount | output | VCNT_W | Current line position in the frame |
| frameEnd | output | 1 | Pulse on the last pixel tick of a frame |
| frameDone | output | 1 | Pulse once the raster has stopped |

## Verification
Position, sync and data-enable outputs change in the cycle after the clock edge on which `pixelTick` was high. `frameEnd` and `pixelTick` are combinational on the current phase. `frameDone` appears exactly one cycle after the final tick of a stopping frame. The bench advances an arithmetic model of divider phase, position and run state once per clock edge, computed from the programmed numbers. It compares every output at the falling edge that follows, so each result is checked in the cycle in which it is due. Configurations sweep minimum fields, zero porches, divisor values below two, all three inversions, and the high-order bits stored in the extension word.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // Field widths fixed by the timing word packing
  localparam int HFIELD_W  = 10;
  localparam int WIDTH_F_W = 7;
  localparam int LINES_F_W = 11;
  localparam int VPORCH_W  = 8;
  localparam int VSYNC_F_W = 6;
  localparam int PIX_UNIT  = 16;

  localparam int HTOTAL_MAX = (2 ** WIDTH_F_W) * PIX_UNIT + 3 * (2 ** HFIELD_W);
  localparam int VTOTAL_MAX = (2 ** LINES_F_W) + 2 * (2 ** VPORCH_W - 1) + (2 ** VSYNC_F_W);
  localparam int HCNT_W = $clog2(HTOTAL_MAX + 1);
  localparam int VCNT_W = $clog2(VTOTAL_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } rasterState_t;

  typedef struct packed {
    logic clearPos;   // hold position at origin (raster idle)
    logic step;       // advance one pixel
  } rasterStrobe_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import lcd_raster_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rasterEnable,
  input  logic [DIV_W-1:0]     clkDivisor,
  input  logic                 pclkInvert,
  input  logic                 frameWrap,
  output rasterStrobe_t        strobe,
  output logic                 pixelTick,
  output logic                 pixelClkOut,
  output logic                 frameEnd,
  output logic                 frameDone
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  rasterState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divEff;
  logic running;
  logic stopping;

  assign divEff    = (clkDivisor < MIN_DIV) ? MIN_DIV : clkDivisor;
  assign running   = (state != ST_IDLE);
  assign pixelTick = running && (divCnt >= divEff - DIV_W'(1));
  assign stopping  = (state == ST_DRAIN) || ((state == ST_RUN) && !rasterEnable);
  assign frameEnd  = pixelTick && frameWrap;

  assign strobe.clearPos = !running;
  assign strobe.step     = pixelTick;

  assign pixelClkOut = (running && (divCnt >= (divEff >> 1))) ^ pclkInvert;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!running) begin
        divCnt <= '0;
        if (rasterEnable) state <= ST_RUN;
      end else begin
        divCnt <= pixelTick ? '0 : divCnt + DIV_W'(1);
        if (stopping && frameEnd) begin
          state     <= ST_IDLE;
          frameDone <= 1'b1;
        end else if ((state == ST_RUN) && !rasterEnable) begin
          state <= ST_DRAIN;
        end
      end
    end
  end

  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    pixelTick |=> !pixelTick)
    else $error("tick spacing below two cycles");

  p_done_after_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(frameEnd))
    else $error("frame done without a preceding frame end");

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone)
    else $error("frame done longer than one cycle");

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !pixelTick)
    else $error("tick while reporting frame done");
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import lcd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rasterStrobe_t      strobe,
  input  logic [31:0]        timingWord0,
  input  logic [31:0]        timingWord1,
  input  logic [31:0]        timingWord2,
  input  logic               hsyncInvert,
  input  logic               vsyncInvert,
  output logic               frameWrap,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               dataEnable,
  output logic [HCNT_W-1:0]  pixelCount,
  output logic [VCNT_W-1:0]  lineCount
);
  // Field decode (packing positions are part of the interface)
  logic [HFIELD_W-1:0]  hfpField, hbpField, hswField;
  logic [WIDTH_F_W-1:0] widthField;
  logic [LINES_F_W-1:0] linesField;
  logic [VPORCH_W-1:0]  vfpLines, vbpLines;
  logic [VSYNC_F_W-1:0] vswField;

  assign hfpField   = {timingWord2[1:0],   timingWord0[23:16]};
  assign hbpField   = {timingWord2[5:4],   timingWord0[31:24]};
  assign hswField   = {timingWord2[30:27], timingWord0[15:10]};
  assign widthField = {timingWord0[3],     timingWord0[9:4]};
  assign linesField = {timingWord2[26],    timingWord1[9:0]};
  assign vbpLines   = timingWord1[31:24];
  assign vfpLines   = timingWord1[23:16];
  assign vswField   = timingWord1[15:10];

  logic [HCNT_W-1:0] widthPix, hSyncStart, hSyncEnd, hTotal;
  logic [VCNT_W-1:0] linesAct, vSyncStart, vSyncEnd, vTotal;

  assign widthPix   = (HCNT_W'(widthField) + HCNT_W'(1)) * HCNT_W'(PIX_UNIT);
  assign hSyncStart = widthPix   + HCNT_W'(hfpField) + HCNT_W'(1);
  assign hSyncEnd   = hSyncStart + HCNT_W'(hswField) + HCNT_W'(1);
  assign hTotal     = hSyncEnd   + HCNT_W'(hbpField) + HCNT_W'(1);

  assign linesAct   = VCNT_W'(linesField) + VCNT_W'(1);
  assign vSyncStart = linesAct   + VCNT_W'(vfpLines);
  assign vSyncEnd   = vSyncStart + VCNT_W'(vswField) + VCNT_W'(1);
  assign vTotal     = vSyncEnd   + VCNT_W'(vbpLines);

  logic [HCNT_W-1:0] hCount;
  logic [VCNT_W-1:0] vCount;
  logic vsyncState;
  logic lineLast, hsyncTrail;

  assign lineLast   = (hCount == hTotal - HCNT_W'(1));
  assign frameWrap  = lineLast && (vCount == vTotal - VCNT_W'(1));
  assign hsyncTrail = (hCount == hSyncEnd - HCNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearPos) begin
      hCount     <= '0;
      vCount     <= '0;
      vsyncState <= 1'b0;
    end else if (strobe.step) begin
      if (lineLast) begin
        hCount <= '0;
        vCount <= (vCount == vTotal - VCNT_W'(1)) ? '0 : vCount + VCNT_W'(1);
      end else begin
        hCount <= hCount + HCNT_W'(1);
      end
      // vertical sync follows the trailing edge of horizontal sync
      if (hsyncTrail)
        vsyncState <= (vCount >= vSyncStart - VCNT_W'(1)) &&
                      (vCount <  vSyncEnd   - VCNT_W'(1));
    end
  end

  logic active;
  assign active     = !strobe.clearPos;
  assign hsyncOut   = (active && (hCount >= hSyncStart) && (hCount < hSyncEnd)) ^ hsyncInvert;
  assign vsyncOut   = (active && vsyncState) ^ vsyncInvert;
  assign dataEnable = active && (hCount < widthPix) && (vCount < linesAct);
  assign pixelCount = hCount;
  assign lineCount  = vCount;

  p_hcount_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    hCount < hTotal)
    else $error("pixel position beyond line length");

  p_vsync_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(vsyncState) && !$past(strobe.clearPos)) |-> (hCount == hSyncEnd))
    else $error("vertical sync moved away from horizontal sync trailing edge");

  p_line_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.clearPos) && (vCount != $past(vCount))) |-> (hCount == '0))
    else $error("line advanced mid-line");
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rasterEnable,
  input  logic [31:0]        timingWord0,
  input  logic [31:0]        timingWord1,
  input  logic [31:0]        timingWord2,
  input  logic [DIV_W-1:0]   clkDivisor,
  input  logic               hsyncInvert,
  input  logic               vsyncInvert,
  input  logic               pclkInvert,
  output logic               pixelTick,
  output logic               pixelClkOut,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               dataEnable,
  output logic [HCNT_W-1:0]  pixelCount,
  output logic [VCNT_W-1:0]  lineCount,
  output logic               frameEnd,
  output logic               frameDone
);
  rasterStrobe_t strobe;
  logic frameWrap;

  raster_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rasterEnable(rasterEnable),
    .clkDivisor  (clkDivisor),
    .pclkInvert  (pclkInvert),
    .frameWrap   (frameWrap),
    .strobe      (strobe),
    .pixelTick   (pixelTick),
    .pixelClkOut (pixelClkOut),
    .frameEnd    (frameEnd),
    .frameDone   (frameDone)
  );

  raster_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .timingWord0 (timingWord0),
    .timingWord1 (timingWord1),
    .timingWord2 (timingWord2),
    .hsyncInvert (hsyncInvert),
    .vsyncInvert (vsyncInvert),
    .frameWrap   (frameWrap),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .dataEnable  (dataEnable),
    .pixelCount  (pixelCount),
    .lineCount   (lineCount)
  );
endmodule

// File: tb/test_lcd_raster_timer.sv
`timescale 1ns/1ps
module test_lcd_raster_timer;
  import lcd_raster_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasterEnable = 1'b0;
  logic [31:0] timingWord0 = '0, timingWord1 = '0, timingWord2 = '0;
  logic [7:0] clkDivisor = 8'd2;
  logic hsyncInvert = 1'b0, vsyncInvert = 1'b0, pclkInvert = 1'b0;
  logic pixelTick, pixelClkOut, hsyncOut, vsyncOut, dataEnable, frameEnd, frameDone;
  logic [HCNT_W-1:0] pixelCount;
  logic [VCNT_W-1:0] lineCount;

  always #2.5 clk = ~clk;

  lcd_raster_timer i_lcd_raster_timer (
    .clk(clk), .rstN(rstN), .rasterEnable(rasterEnable),
    .timingWord0(timingWord0), .timingWord1(timingWord1), .timingWord2(timingWord2),
    .clkDivisor(clkDivisor), .hsyncInvert(hsyncInvert), .vsyncInvert(vsyncInvert),
    .pclkInvert(pclkInvert), .pixelTick(pixelTick), .pixelClkOut(pixelClkOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEnable(dataEnable),
    .pixelCount(pixelCount), .lineCount(lineCount), .frameEnd(frameEnd),
    .frameDone(frameDone)
  );

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  // programmed numbers
  int mWidth, mHfp, mHsw, mHbp, mLines, mVfp, mVsw, mVbp, mDiv;
  int mHt, mVt, mHsStart, mHsEnd, mVsStart, mVsEnd;
  int mHi, mVi, mPi;
  // model state
  int mRun, mDv, mH, mV, mDone;

  task automatic chk(string req, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d (pos %0d,%0d)", req, what, act, exp, mH, mV);
    end
  endtask

  task automatic checkOutputs(string tag);
    int pos, vsStartPos, vsEndPos, expTick, expHs, expVs, expDe;
    expTick = (mRun != 0 && mDv == mDiv - 1) ? 1 : 0;
    pos = mV * mHt + mH;
    vsStartPos = (mVsStart - 1) * mHt + mHsEnd;
    vsEndPos   = (mVsEnd - 1) * mHt + mHsEnd;
    expHs = (mRun != 0 && mH >= mHsStart && mH < mHsEnd) ? 1 : 0;
    expVs = (mRun != 0 && pos >= vsStartPos && pos < vsEndPos) ? 1 : 0;
    expDe = (mRun != 0 && mH < mWidth && mV < mLines) ? 1 : 0;
    chk({"R1 ", tag}, "pixelTick", int'(pixelTick), expTick);
    chk({"R9 ", tag}, "pixelClkOut", int'(pixelClkOut),
        ((mRun != 0 && mDv >= mDiv / 2) ? 1 : 0) ^ mPi);
    chk({"R7 ", tag}, "hsyncOut", int'(hsyncOut), expHs ^ mHi);
    chk({"R8 ", tag}, "vsyncOut", int'(vsyncOut), expVs ^ mVi);
    chk({"R6 ", tag}, "dataEnable", int'(dataEnable), expDe);
    chk({"R6 ", tag}, "pixelCount", int'(pixelCount), mH);
    chk({"R6 ", tag}, "lineCount", int'(lineCount), mV);
    chk({"R10 ", tag}, "frameEnd", int'(frameEnd),
        (expTick != 0 && mH == mHt - 1 && mV == mVt - 1) ? 1 : 0);
    chk({"R11 ", tag}, "frameDone", int'(frameDone), mDone);
  endtask

  // model of the clock edge between now and the next falling edge
  task automatic advanceModel();
    mDone = 0;
    if (mRun == 0) begin
      if (rasterEnable) mRun = 1;
      mDv = 0; mH = 0; mV = 0;
    end else if (mDv == mDiv - 1) begin
      mDv = 0;
      if (mH == mHt - 1 && mV == mVt - 1 && !rasterEnable) begin
        mRun = 0;
        mDone = 1;
      end
      if (mH == mHt - 1) begin
        mH = 0;
        mV = (mV == mVt - 1) ? 0 : mV + 1;
      end else begin
        mH = mH + 1;
      end
    end else begin
      mDv = mDv + 1;
    end
  endtask

  task automatic cycle(string tag);
    advanceModel();
    @(negedge clk);
    checkOutputs(tag);
  endtask

  task automatic runConfig(string tag, int w16, int hfp, int hsw, int hbp,
                           int lines, int vfp, int vsw, int vbp, int div,
                           int hi, int vi, int pi, int frames);
    logic [9:0] hfpF, hswF, hbpF;
    logic [6:0] wF;
    logic [10:0] lF;
    logic [5:0] vswF;
    int runCycles, waitLimit;
    hfpF = 10'(hfp - 1); hswF = 10'(hsw - 1); hbpF = 10'(hbp - 1);
    wF = 7'(w16 - 1); lF = 11'(lines - 1); vswF = 6'(vsw - 1);
    mWidth = w16 * 16; mHfp = hfp; mHsw = hsw; mHbp = hbp;
    mLines = lines; mVfp = vfp; mVsw = vsw; mVbp = vbp;
    mDiv = (div < 2) ? 2 : div;
    mHsStart = mWidth + hfp; mHsEnd = mHsStart + hsw; mHt = mHsEnd + hbp;
    mVsStart = lines + vfp; mVsEnd = mVsStart + vsw; mVt = mVsEnd + vbp;
    mHi = hi; mVi = vi; mPi = pi;
    timingWord0 = {hbpF[7:0], hfpF[7:0], hswF[5:0], wF[5:0], wF[6], 3'b000};
    timingWord1 = {8'(vbp), 8'(vfp), vswF, lF[9:0]};
    timingWord2 = {1'b0, hswF[9:6], lF[10], 20'd0, hbpF[9:8], 2'b00, hfpF[9:8]};
    clkDivisor = 8'(div);
    hsyncInvert = 1'(hi); vsyncInvert = 1'(vi); pclkInvert = 1'(pi);
    cycle(tag);                       // idle with new polarity settings
    rasterEnable = 1'b1;
    runCycles = frames * mHt * mVt * mDiv + 7;
    for (int c = 0; c < runCycles; c++) cycle(tag);
    rasterEnable = 1'b0;
    waitLimit = mHt * mVt * mDiv + 8;
    for (int c = 0; c < waitLimit; c++) begin
      cycle(tag);
      if (mDone != 0) break;
    end
    chk({"R11 ", tag}, "drain reached idle", mDone, 1);
    for (int c = 0; c < 4; c++) cycle(tag);   // idle: position held, no tick
  endtask

  initial begin
    mRun = 0; mDv = 0; mH = 0; mV = 0; mDone = 0;
    mDiv = 2; mHt = 1; mVt = 1; mWidth = 16; mLines = 1;
    mHsStart = 0; mHsEnd = 0; mVsStart = 1; mVsEnd = 1; mHi = 0; mVi = 0; mPi = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R11 reset", "dataEnable", int'(dataEnable), 0);
    chk("R11 reset", "frameDone", int'(frameDone), 0);
    chk("R1 reset", "pixelTick", int'(pixelTick), 0);
    chk("R6 reset", "pixelCount", int'(pixelCount), 0);
    chk("R6 reset", "lineCount", int'(lineCount), 0);
    rstN = 1'b1;
    //          tag   w16 hfp hsw hbp lines vfp vsw vbp div hi vi pi frames
    runConfig("R6",   1,  1,  1,  1,  2,    0,  1,  0,  2,  0, 0, 0, 2);
    runConfig("R7",   2,  3,  2,  4,  3,    1,  2,  1,  3,  1, 0, 0, 2);
    runConfig("R8",   1,  2,  3,  2,  4,    2,  1,  2,  0,  0, 1, 1, 2);
    runConfig("R1",   1,  1,  2,  1,  1,    0,  3,  1,  1,  1, 1, 0, 2);
    runConfig("R9",   1,  2,  1,  3,  2,    1,  1,  0,  5,  0, 0, 1, 1);
    runConfig("R2",   1,  300, 70, 260, 1,  1,  1,  0,  2,  0, 0, 0, 1);
    runConfig("R3",   65, 1,  1,  1,  2,    0,  1,  0,  2,  0, 0, 0, 1);
    runConfig("R4",   1,  1,  1,  1,  1025, 0,  1,  0,  2,  0, 0, 0, 0);
    runConfig("R5",   1,  1,  1,  1,  2,    255, 64, 255, 2, 0, 1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule